// File: doc/BRIEF.md
# DMA Channel Termination Controller

This block holds the per-channel and global stop logic of a multi-channel DMA engine. Each channel keeps a source address, a destination address, a remaining-transfer count, an enable bit, an interrupt enable, a bridge-mode bit and a transfer-end flag. A global master enable, an NMI flag and an address-error flag can halt every channel at once. The data path, bus arbitration and the request sources outside the block are reduced to strobes: `req` asks for one transfer on a channel, `xfer_done` reports that the granted transfer finished, and `ae_set` reports an address error from the bus.

Only a count that reaches zero counts as a normal finish. That event sets the end flag, clears the enable bit and can raise the interrupt. A channel disable, an NMI or a master-enable clear takes effect at the next transfer boundary. An address error aborts the transfer in flight. In both of these cases the address and count registers are left holding the values for the transfer that would run next, and the end flag stays clear. The address-error flag can only be cleared by a write of zero that follows a read which returned one.

Top module: `dma_stop_ctrl`

## Requirements
- R1: Each `xfer_done` pulse during a grant decrements that channel's count by one. When the increment bit is 1, the source and destination addresses advance by 2^size, with size 0, 1 or 2. When the increment bit is 0, both addresses stay fixed. No count changes while nothing is granted.
- R2: When a completed transfer takes the count from 1 to 0, the channel's end flag becomes 1, its enable bit becomes 0, and the channel stops. The end flag is never set at any other time.
- R3: `irq` is 1 while any channel has its end flag and interrupt enable both set and its bridge-mode bit clear. A channel in bridge mode never drives `irq`.
- R4: Clearing a channel's enable bit during a transfer lets that transfer finish and update the registers. The channel then stops with its end flag still 0.
- R5: Setting the NMI flag, or writing 0 to the master enable, stops every channel at the next boundary. The transfer in flight still completes and updates its registers.
- R6: An `ae_set` pulse during a transfer ends the grant at once, without updating the address or count registers, and the end flag stays 0.
- R7: While the address-error flag is 1, requests are dropped and not remembered. After recovery, a request made during the error never starts a transfer; only a new request does.
- R8: The address-error flag is cleared only by `ae_wr0` after an `ae_rd` seen while the flag was 1. An `ae_wr0` without such a read leaves the flag at 1.
- R9: When several runnable channels have pending requests, the lowest-numbered one is granted first.
- R10: A channel whose end flag is set does not start, even after its count is reloaded. It restarts only after its end flag is cleared and its enable bit is set again.
- R11: After reset, every flag, enable and count is 0, `busy` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load the configuration of channel `cfg_ch` |
| cfg_ch | input | CHW | Channel to configure |
| cfg_sar | input | AW | Source address to load |
| cfg_dar | input | AW | Destination address to load |
| cfg_cnt | input | CW | Transfer count to load |
| cfg_inc | input | 1 | 1: addresses advance after each transfer |
| cfg_size | input | 2 | Log2 of the transfer size in bytes (0..2) |
| cfg_ie | input | 1 | Interrupt enable |
| cfg_brg | input | 1 | Bridge mode (suppresses the interrupt) |
| en_set | input | NCH | Set a channel's enable bit |
| en_clr | input | NCH | Clear a channel's enable bit |
| te_clr | input | NCH | Clear a channel's end flag |
| dme_we | input | 1 | Write the master enable |
| dme_val | input | 1 | Value written to the master enable |
| nmi_set | input | 1 | Set the NMI flag |
| nmi_clr | input | 1 | Clear the NMI flag |
| ae_set | input | 1 | Address error reported by the bus |
| ae_rd | input | 1 | Software read of the address-error flag |
| ae_wr0 | input | 1 | Software write of 0 to the address-error flag |
| req | input | NCH | One-cycle transfer request for each channel |
| xfer_done | input | 1 | The granted transfer has completed |
| busy | output | 1 | A transfer is granted and in flight |
| grant_ch | output | CHW | Channel that holds the grant |
| sar_o | output | NCH*AW | Source addresses, channel 0 in the low bits |
| dar_o | output | NCH*AW | Destination addresses, channel 0 in the low bits |
| cnt_o | output | NCH*CW | Remaining counts, channel 0 in the low bits |
| en_o | output | NCH | Channel enable bits |
| te_o | output | NCH | Channel end flags |
| dme_o | output | 1 | Master enable |
| nmi_o | output | 1 | NMI flag |
| ae_o | output | 1 | Address-error flag |
| irq | output | 1 | Transfer-end interrupt |

## Verification
The bench sweeps every transfer size, both address modes and counts of one to three. It checks the count and both addresses after every transfer, so a wrong step or an off-by-one in the terminal count shows up as a wrong address or a flag that rises one transfer early or late. It clears the channel enable, raises NMI and drops the master enable while a transfer is in flight. A design that cut the transfer short would leave the count unchanged, and one that treated the stop as a finish would set the end flag. For the address error, the bench checks that the abort freezes the registers and that a bare write of zero leaves the flag set. It also checks that a request made during the error never starts a transfer later, which catches a design that queues requests. Bridge-mode interrupt masking, lowest-channel priority and the end-flag restart interlock each have their own directed case.

// File: rtl/dma_stop_ctrl.sv
module dma_stop_ctrl #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CHW-1:0]    cfg_ch,
  input  logic [AW-1:0]     cfg_sar,
  input  logic [AW-1:0]     cfg_dar,
  input  logic [CW-1:0]     cfg_cnt,
  input  logic              cfg_inc,
  input  logic [1:0]        cfg_size,
  input  logic              cfg_ie,
  input  logic              cfg_brg,
  input  logic [NCH-1:0]    en_set,
  input  logic [NCH-1:0]    en_clr,
  input  logic [NCH-1:0]    te_clr,
  input  logic              dme_we,
  input  logic              dme_val,
  input  logic              nmi_set,
  input  logic              nmi_clr,
  input  logic              ae_set,
  input  logic              ae_rd,
  input  logic              ae_wr0,
  input  logic [NCH-1:0]    req,
  input  logic              xfer_done,
  output logic              busy,
  output logic [CHW-1:0]    grant_ch,
  output logic [NCH*AW-1:0] sar_o,
  output logic [NCH*AW-1:0] dar_o,
  output logic [NCH*CW-1:0] cnt_o,
  output logic [NCH-1:0]    en_o,
  output logic [NCH-1:0]    te_o,
  output logic              dme_o,
  output logic              nmi_o,
  output logic              ae_o,
  output logic              irq
);

  logic [AW-1:0]  sar [NCH];
  logic [AW-1:0]  dar [NCH];
  logic [CW-1:0]  cnt [NCH];
  logic [AW-1:0]  step [NCH];
  logic [1:0]     sz [NCH];
  logic [NCH-1:0] inc, ie, brg, en, te, pend, runnable, hit;
  logic           dme, nmi, ae, ae_arm;
  logic [CHW-1:0] cur, sel;
  logic           sel_vld, start, glb_ok;

  assign glb_ok = dme & ~ae & ~nmi;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      assign step[g]     = inc[g] ? (AW'(1) << sz[g]) : '0;
      assign runnable[g] = en[g] & ~te[g] & (cnt[g] != '0) & glb_ok;
      assign hit[g]      = busy & xfer_done & ~ae_set & (cur == CHW'(g));
      assign sar_o[g*AW +: AW] = sar[g];
      assign dar_o[g*AW +: AW] = dar[g];
      assign cnt_o[g*CW +: CW] = cnt[g];
    end
  endgenerate

  always_comb begin
    sel_vld = 1'b0;
    sel     = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (runnable[i] && pend[i]) begin
        sel_vld = 1'b1;
        sel     = CHW'(i);
      end
  end

  assign start = ~busy & sel_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        sar[i] <= '0;
        dar[i] <= '0;
        cnt[i] <= '0;
        sz[i]  <= '0;
      end
      inc  <= '0;
      ie   <= '0;
      brg  <= '0;
      en   <= '0;
      te   <= '0;
      pend <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (cfg_we && cfg_ch == CHW'(i)) begin
          sar[i] <= cfg_sar;
          dar[i] <= cfg_dar;
          cnt[i] <= cfg_cnt;
          inc[i] <= cfg_inc;
          sz[i]  <= cfg_size;
          ie[i]  <= cfg_ie;
          brg[i] <= cfg_brg;
        end else if (hit[i]) begin
          cnt[i] <= cnt[i] - CW'(1);
          sar[i] <= sar[i] + step[i];
          dar[i] <= dar[i] + step[i];
        end
        if (hit[i] && cnt[i] == CW'(1)) en[i] <= 1'b0;
        else if (en_clr[i])             en[i] <= 1'b0;
        else if (en_set[i])             en[i] <= 1'b1;
        if (hit[i] && cnt[i] == CW'(1)) te[i] <= 1'b1;
        else if (te_clr[i])             te[i] <= 1'b0;
        pend[i] <= runnable[i] & ~ae_set &
                   (req[i] | (pend[i] & ~(start && sel == CHW'(i))));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cur  <= '0;
    end else if (ae_set) begin
      busy <= 1'b0;
    end else if (busy && xfer_done) begin
      busy <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      cur  <= sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dme    <= 1'b0;
      nmi    <= 1'b0;
      ae     <= 1'b0;
      ae_arm <= 1'b0;
    end else begin
      if (dme_we) dme <= dme_val;
      if (nmi_set)      nmi <= 1'b1;
      else if (nmi_clr) nmi <= 1'b0;
      if (ae_set) begin
        ae     <= 1'b1;
        ae_arm <= 1'b0;
      end else if (ae_wr0 && ae_arm) begin
        ae     <= 1'b0;
        ae_arm <= 1'b0;
      end else if (ae_rd && ae) begin
        ae_arm <= 1'b1;
      end
    end
  end

  assign grant_ch = cur;
  assign en_o     = en;
  assign te_o     = te;
  assign dme_o    = dme;
  assign nmi_o    = nmi;
  assign ae_o     = ae;
  assign irq      = |(te & ie & ~brg);

  generate
    for (g = 0; g < NCH; g++) begin : g_chk
      AST_TE_ONLY_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(te[g]) |-> cnt[g] == '0); // R2
    end
  endgenerate

  AST_IDLE_COUNTS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !cfg_we |=> $stable(cnt_o)); // R1
  AST_INFLIGHT_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !xfer_done && !ae_set |=> busy); // R4
  AST_ABORT_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ae_set && !cfg_we |=> !busy && $stable(cnt_o) && $stable(sar_o)); // R6
  AST_NO_START_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && (ae || nmi || !dme) |=> !busy); // R5
  AST_AE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ae && !ae_wr0 |=> ae); // R8

endmodule

// File: tb/dma_stop_ctrl_bench.sv
module dma_stop_ctrl_bench;
  localparam int NCH = 4, AW = 16, CW = 8, CHW = 2;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_inc = 0, cfg_ie = 0, cfg_brg = 0;
  logic [CHW-1:0] cfg_ch = 0;
  logic [AW-1:0] cfg_sar = 0, cfg_dar = 0;
  logic [CW-1:0] cfg_cnt = 0;
  logic [1:0] cfg_size = 0;
  logic [NCH-1:0] en_set = 0, en_clr = 0, te_clr = 0, req = 0;
  logic dme_we = 0, dme_val = 0, nmi_set = 0, nmi_clr = 0;
  logic ae_set = 0, ae_rd = 0, ae_wr0 = 0, xfer_done = 0;
  logic busy, dme_o, nmi_o, ae_o, irq;
  logic [CHW-1:0] grant_ch;
  logic [NCH*AW-1:0] sar_o, dar_o;
  logic [NCH*CW-1:0] cnt_o;
  logic [NCH-1:0] en_o, te_o;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  dma_stop_ctrl #(.NCH(NCH), .AW(AW), .CW(CW)) u_dma_stop_ctrl (
    .clk, .rst_n, .cfg_we, .cfg_ch, .cfg_sar, .cfg_dar, .cfg_cnt, .cfg_inc,
    .cfg_size, .cfg_ie, .cfg_brg, .en_set, .en_clr, .te_clr, .dme_we, .dme_val,
    .nmi_set, .nmi_clr, .ae_set, .ae_rd, .ae_wr0, .req, .xfer_done, .busy,
    .grant_ch, .sar_o, .dar_o, .cnt_o, .en_o, .te_o, .dme_o, .nmi_o, .ae_o, .irq);

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic int cnt_of(int c); return int'(cnt_o[c*CW +: CW]); endfunction
  function automatic int sar_of(int c); return int'(sar_o[c*AW +: AW]); endfunction
  function automatic int dar_of(int c); return int'(dar_o[c*AW +: AW]); endfunction

  task automatic tick(); @(negedge clk); endtask

  task automatic cfg(input int c, input int s, input int d, input int n,
                     input bit inc, input int size, input bit ie_b, input bit brg_b);
    cfg_ch = CHW'(c); cfg_sar = AW'(s); cfg_dar = AW'(d); cfg_cnt = CW'(n);
    cfg_inc = inc; cfg_size = 2'(size); cfg_ie = ie_b; cfg_brg = brg_b; cfg_we = 1;
    tick(); cfg_we = 0;
  endtask

  task automatic enable(input int c); en_set[c] = 1; tick(); en_set = 0; endtask
  task automatic clear_te(input int c); te_clr[c] = 1; tick(); te_clr = 0; endtask
  task automatic request(input int c); req[c] = 1; tick(); req = 0; tick(); endtask
  task automatic finish_xfer(); xfer_done = 1; tick(); xfer_done = 0; endtask

  task automatic run_one(input int c, input string r);
    request(c);
    chk({r, " busy"}, busy, 1);
    chk({r, " grant"}, grant_ch, c);
    finish_xfer();
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(); tick(); rst_n = 1; tick();
    // R11 reset state
    chk("R11 busy", busy, 0);
    chk("R11 te", te_o, 0);
    chk("R11 en", en_o, 0);
    chk("R11 cnt", int'(cnt_o[CW-1:0]), 0);
    chk("R11 ae", ae_o, 0);
    chk("R11 irq", irq, 0);
    chk("R11 dme", dme_o, 0);
    dme_val = 1; dme_we = 1; tick(); dme_we = 0;

    // R1 R2 R3 sweep over size, increment mode and count
    for (int sz = 0; sz < 3; sz++)
      for (int inc = 0; inc < 2; inc++)
        for (int n = 1; n <= 3; n++) begin
          clear_te(0);
          cfg(0, 'h100, 'h800, n, inc[0], sz, 1, 0);
          enable(0);
          for (int k = 0; k < n; k++) begin
            run_one(0, "R1");
            chk("R1 cnt", cnt_of(0), n - 1 - k);
            chk("R1 sar", sar_of(0), 'h100 + (k + 1) * (inc ? (1 << sz) : 0));
            chk("R1 dar", dar_of(0), 'h800 + (k + 1) * (inc ? (1 << sz) : 0));
            if (k < n - 1) chk("R2 te early", te_o[0], 0);
          end
          chk("R2 te", te_o[0], 1);
          chk("R2 en", en_o[0], 0);
          chk("R2 busy", busy, 0);
          chk("R3 irq", irq, 1);
        end
    clear_te(0);
    chk("R3 irq cleared", irq, 0);

    // R3 bridge mode masks interrupt
    cfg(1, 'h0, 'h0, 1, 0, 0, 1, 1);
    enable(1);
    run_one(1, "R3");
    chk("R3 bridge te", te_o[1], 1);
    chk("R3 bridge irq", irq, 0);
    clear_te(1);

    // R10 restart interlock
    cfg(2, 'h10, 'h20, 1, 1, 0, 0, 0);
    enable(2);
    run_one(2, "R10");
    chk("R10 te", te_o[2], 1);
    cfg(2, 'h10, 'h20, 2, 1, 0, 0, 0);
    en_set[2] = 1; tick(); en_set = 0;
    request(2); tick();
    chk("R10 te blocks", busy, 0);
    clear_te(2);
    en_clr[2] = 1; tick(); en_clr = 0;
    request(2); tick();
    chk("R10 enable needed", busy, 0);
    enable(2);
    run_one(2, "R10");
    chk("R10 restarted cnt", cnt_of(2), 1);
    en_clr[2] = 1; tick(); en_clr = 0;

    // R4 channel disable at boundary
    cfg(0, 'h300, 'h400, 5, 1, 1, 1, 0);
    enable(0);
    request(0);
    chk("R4 busy", busy, 1);
    en_clr[0] = 1; tick(); en_clr = 0;
    chk("R4 still busy", busy, 1);
    finish_xfer();
    chk("R4 cnt", cnt_of(0), 4);
    chk("R4 sar", sar_of(0), 'h302);
    chk("R4 te", te_o[0], 0);
    chk("R4 irq", irq, 0);
    request(0); tick();
    chk("R4 stopped", busy, 0);

    // R5 NMI at boundary
    enable(0);
    request(0);
    nmi_set = 1; tick(); nmi_set = 0;
    chk("R5 nmi busy", busy, 1);
    finish_xfer();
    chk("R5 nmi cnt", cnt_of(0), 3);
    chk("R5 nmi te", te_o[0], 0);
    request(0); tick();
    chk("R5 nmi halt", busy, 0);
    nmi_clr = 1; tick(); nmi_clr = 0;
    run_one(0, "R5");
    chk("R5 resume cnt", cnt_of(0), 2);
    // R5 master enable cleared
    request(0);
    dme_val = 0; dme_we = 1; tick(); dme_we = 0;
    chk("R5 dme busy", busy, 1);
    finish_xfer();
    chk("R5 dme cnt", cnt_of(0), 1);
    request(0); tick();
    chk("R5 dme halt", busy, 0);
    dme_val = 1; dme_we = 1; tick(); dme_we = 0;
    en_clr[0] = 1; tick(); en_clr = 0;

    // R6 address error abort
    cfg(1, 'h200, 'h600, 3, 1, 2, 1, 0);
    enable(1);
    request(1);
    chk("R6 busy", busy, 1);
    ae_set = 1; xfer_done = 1; tick(); ae_set = 0; xfer_done = 0;
    chk("R6 aborted", busy, 0);
    chk("R6 cnt", cnt_of(1), 3);
    chk("R6 sar", sar_of(1), 'h200);
    chk("R6 dar", dar_of(1), 'h600);
    chk("R6 te", te_o[1], 0);
    chk("R6 ae", ae_o, 1);

    // R7 requests dropped, R8 clear protocol
    request(1); tick();
    chk("R7 ignored", busy, 0);
    ae_wr0 = 1; tick(); ae_wr0 = 0;
    chk("R8 bare write", ae_o, 1);
    ae_rd = 1; tick(); ae_rd = 0;
    ae_wr0 = 1; tick(); ae_wr0 = 0;
    chk("R8 cleared", ae_o, 0);
    tick(); tick();
    chk("R7 not queued", busy, 0);
    run_one(1, "R7");
    chk("R7 resumed cnt", cnt_of(1), 2);
    chk("R7 resumed sar", sar_of(1), 'h204);

    // R9 fixed priority
    cfg(3, 'h0, 'h0, 2, 0, 0, 0, 0);
    enable(3);
    req[1] = 1; req[3] = 1; tick(); req = 0; tick();
    chk("R9 first", grant_ch, 1);
    chk("R9 busy", busy, 1);
    finish_xfer();
    tick();
    chk("R9 second", grant_ch, 3);
    chk("R9 busy2", busy, 1);
    finish_xfer();
    chk("R9 cnt1", cnt_of(1), 1);
    chk("R9 cnt3", cnt_of(3), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule